// File: doc/BRIEF.md
# DMA Channel Transfer Sequencer

This block is the transfer engine behind a four-channel DMA controller. The register interface supplies each channel's configuration (transfer mode, transfer type, address direction, auto-reload, byte or word width, page), its base offset and base count, and one-cycle strobes that load the working registers, set or clear the channel mask, or post a software request. Peripherals drive one request line per channel. The sequencer picks one eligible channel, runs one memory cycle per transfer unit and drives a physical address. It returns an acknowledge to the channel being served, a terminal-count pulse, and per-channel status flags.

The count register holds the transfer length minus one and decrements after each unit. The terminal unit is the one in which the count is zero, after which the count reads all ones. At that point the channel either reloads its working offset and count from the base values and stays armed, or masks itself. The offset moves by one per unit, up or down, and wraps inside 16 bits, so the page never changes during a transfer. Channels are picked by fixed priority or by round robin, and a command input can stop all new grants.

Top module: `dma_xfer_seq`

## Requirements
- R1: A count programmed as N moves N+1 units. The unit in which the count is 0 is the terminal unit, and after it the count reads 0xFFFF (when auto-reload is off).
- R2: After each unit the count drops by one and the offset steps by one: down when `ch_dec` is 1, up when it is 0.
- R3: The offset wraps within 16 bits (0x0000 to 0xFFFF going down, 0xFFFF to 0x0000 going up) and the page part of the address does not change.
- R4: At the terminal unit, a channel with `ch_auto`=1 reloads offset and count from `base_addr`/`base_cnt` and stays unmasked. A channel with `ch_auto`=0 sets its mask.
- R5: The address for a byte channel (`ch_word`=0) is page[3:0]×65536 + offset. For a word channel it is page×131072 + offset×2, truncated to 24 bits.
- R6: Mode field `ch_mode` (2 bits per channel). 01 (single, and 11 acts the same) moves one unit per grant and then leaves at least one cycle with no unit. 10 (block) moves back-to-back units until the terminal unit. 00 (demand) moves back-to-back units for as long as the channel's request stays asserted.
- R7: With `cmd_rotate`=0, the lowest-numbered eligible channel is served. With `cmd_rotate`=1, the search starts after the channel served last, so that channel becomes lowest.
- R8: While `cmd_disable` is 1, no new grant is made. Grants resume once it returns to 0.
- R9: A `sw_req_set` strobe starts an unmasked channel without its `hw_req`. The software request clears at the channel's terminal unit.
- R10: After reset every channel is masked. A masked channel is never granted, and its `hw_req` has no effect on units or counts.
- R11: During each unit cycle, `dack` is one-hot on the served channel. Type field `ch_type` 10 (read) raises `mem_rd`, 01 (write) raises `mem_wr`, and 00 (verify) raises neither while still updating offset and count.
- R12: `tc_pulse` is high for exactly the terminal unit's cycle on that channel. The channel's `done_flags` bit then sets, and it clears on `ld_cur`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_disable | input | 1 | Blocks all new grants |
| cmd_rotate | input | 1 | 1 = round-robin priority, 0 = fixed |
| ch_mode | input | 2×NCH | Per-channel mode: 00 demand, 01 single, 10 block |
| ch_type | input | 2×NCH | Per-channel type: 00 verify, 01 write, 10 read |
| ch_dec | input | NCH | Offset steps down when 1 |
| ch_auto | input | NCH | Reload from base at terminal unit |
| ch_word | input | NCH | 1 = word channel, 0 = byte channel |
| ch_page | input | 8×NCH | Per-channel page |
| base_addr | input | 16×NCH | Per-channel base offset |
| base_cnt | input | 16×NCH | Per-channel base count (length minus one) |
| ld_cur | input | NCH | Copy base into working offset/count, clear done |
| mask_set | input | NCH | Set channel mask |
| mask_clr | input | NCH | Clear channel mask |
| sw_req_set | input | NCH | Post a software request |
| hw_req | input | NCH | Peripheral request lines |
| mem_cyc | output | 1 | A unit cycle is in progress |
| mem_addr | output | 24 | Physical address of the unit |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| dack | output | NCH | Acknowledge to the served channel |
| tc_pulse | output | NCH | Terminal-unit pulse |
| req_flags | output | NCH | Hardware or software request pending |
| done_flags | output | NCH | Terminal count reached |
| ch_masked | output | NCH | Channel mask state |
| cur_addr | output | 16×NCH | Working offsets |
| cur_cnt | output | 16×NCH | Working counts |

## Verification
A request present at a rising edge is seen by the arbiter at the next edge, which opens the unit cycle. `mem_addr`, `dack`, the read/write strobes and `tc_pulse` are therefore valid one full cycle after the request's first edge, and they reflect the working registers at that time. Offset, count, mask and done flags change at the edge that closes the unit. The bench drives inputs 1 ns after a rising edge and samples everything at the falling edge. Its per-channel model predicts each unit's address, strobes and terminal pulse from its own copy of offset and count, and advances that copy only when it observes a unit. Directed waits are counted in whole edges from the drive point, so that a request drop lands before the edge that would otherwise open another grant.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_UNIT = 1'b1
  } seq_st_t;

  localparam logic [1:0] MD_DEMAND = 2'b00;
  localparam logic [1:0] MD_SINGLE = 2'b01;
  localparam logic [1:0] MD_BLOCK  = 2'b10;

  localparam logic [1:0] TY_VERIFY = 2'b00;
  localparam logic [1:0] TY_WRITE  = 2'b01;
  localparam logic [1:0] TY_READ   = 2'b10;

endpackage

// File: rtl/dma_prio_pick.sv
// Priority search over eligible channels; NCH must be a power of two so the
// index wraps by truncation.
module dma_prio_pick #(
  parameter int NCH = 4,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic [NCH-1:0] elig,
  input  logic           rotate,
  input  logic [CHW-1:0] last_srv,
  output logic           any,
  output logic [CHW-1:0] pick
);

  logic [CHW-1:0] start;
  logic [CHW-1:0] idx;

  assign start = rotate ? CHW'(last_srv + 1'b1) : '0;

  always_comb begin
    any  = 1'b0;
    pick = '0;
    idx  = '0;
    for (int i = 0; i < NCH; i++) begin
      idx = CHW'(start + CHW'(i));
      if (!any && elig[idx]) begin
        any  = 1'b1;
        pick = idx;
      end
    end
  end

endmodule

// File: rtl/dma_chan_ctx.sv
// Working state of one channel: offset, count, mask, software request, done.
module dma_chan_ctx #(
  parameter int OW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [OW-1:0] base_addr,
  input  logic [OW-1:0] base_cnt,
  input  logic          dn,
  input  logic          auto_rl,
  input  logic          ld,
  input  logic          msk_set,
  input  logic          msk_clr,
  input  logic          sw_set,
  input  logic          unit,
  output logic [OW-1:0] cur_addr,
  output logic [OW-1:0] cur_cnt,
  output logic          masked,
  output logic          sw_req,
  output logic          done,
  output logic          last_unit
);

  // offset arithmetic: one step, wrapping inside OW bits
  function automatic logic [OW-1:0] f_step(input logic [OW-1:0] a, input logic down);
    if (down) return OW'(a - 1'b1);
    return OW'(a + 1'b1);
  endfunction

  logic tc_evt;      // terminal unit completes this cycle
  logic tc_selfmask; // terminal unit without reload

  assign last_unit   = (cur_cnt == '0);
  assign tc_evt      = unit && last_unit && !ld;
  assign tc_selfmask = tc_evt && !auto_rl;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_addr <= '0;
      cur_cnt  <= '0;
      done     <= 1'b0;
    end else if (ld) begin
      cur_addr <= base_addr;
      cur_cnt  <= base_cnt;
      done     <= 1'b0;
    end else if (unit) begin
      if (last_unit) begin
        done <= 1'b1;
        if (auto_rl) begin
          cur_addr <= base_addr;
          cur_cnt  <= base_cnt;
        end else begin
          cur_addr <= f_step(cur_addr, dn);
          cur_cnt  <= '1;
        end
      end else begin
        cur_addr <= f_step(cur_addr, dn);
        cur_cnt  <= OW'(cur_cnt - 1'b1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)           masked <= 1'b1;
    else if (msk_set)     masked <= 1'b1;
    else if (tc_selfmask) masked <= 1'b1;
    else if (msk_clr)     masked <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      sw_req <= 1'b0;
    else if (sw_set) sw_req <= 1'b1;
    else if (tc_evt) sw_req <= 1'b0;
  end

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (unit && !last_unit && !ld) |=> (cur_cnt == OW'($past(cur_cnt) - 1'b1))); // R2
  AST_AUTO_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (tc_evt && auto_rl) |=> (cur_addr == $past(base_addr) && cur_cnt == $past(base_cnt))); // R4
  AST_TC_SELF_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (tc_evt && !auto_rl) |=> (masked && cur_cnt == '1)); // R1
  AST_DONE_AT_TC: assert property (@(posedge clk) disable iff (!rst_n)
    tc_evt |=> done); // R12

endmodule

// File: rtl/dma_xfer_seq.sv
module dma_xfer_seq
  import dma_seq_pkg::*;
#(
  parameter int NCH = 4,
  parameter int OW  = 16,
  parameter int PGW = 8,
  parameter int BPW = 4,
  parameter int PAW = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_disable,
  input  logic               cmd_rotate,
  input  logic [2*NCH-1:0]   ch_mode,
  input  logic [2*NCH-1:0]   ch_type,
  input  logic [NCH-1:0]     ch_dec,
  input  logic [NCH-1:0]     ch_auto,
  input  logic [NCH-1:0]     ch_word,
  input  logic [PGW*NCH-1:0] ch_page,
  input  logic [OW*NCH-1:0]  base_addr,
  input  logic [OW*NCH-1:0]  base_cnt,
  input  logic [NCH-1:0]     ld_cur,
  input  logic [NCH-1:0]     mask_set,
  input  logic [NCH-1:0]     mask_clr,
  input  logic [NCH-1:0]     sw_req_set,
  input  logic [NCH-1:0]     hw_req,
  output logic               mem_cyc,
  output logic [PAW-1:0]     mem_addr,
  output logic               mem_rd,
  output logic               mem_wr,
  output logic [NCH-1:0]     dack,
  output logic [NCH-1:0]     tc_pulse,
  output logic [NCH-1:0]     req_flags,
  output logic [NCH-1:0]     done_flags,
  output logic [NCH-1:0]     ch_masked,
  output logic [OW*NCH-1:0]  cur_addr,
  output logic [OW*NCH-1:0]  cur_cnt
);

  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1;

  // page-plus-offset address: page is never carried into
  function automatic logic [PAW-1:0] f_phys(input logic [PGW-1:0] pg,
                                            input logic [OW-1:0]  off,
                                            input logic           word);
    if (word) return PAW'({pg, off, 1'b0});
    return PAW'({pg[BPW-1:0], off});
  endfunction

  logic [OW-1:0]  ca [NCH];
  logic [OW-1:0]  cc [NCH];
  logic [NCH-1:0] masked_w, swreq_w, done_w, last_w, unit_w, elig;

  seq_st_t        st;
  logic [CHW-1:0] gnt, last_srv, pick;
  logic           any;

  // named internal events
  logic           grant_evt;
  logic           stop_evt;
  logic [1:0]     gnt_mode;
  logic [1:0]     gnt_type;
  logic           gnt_req;

  assign elig      = (hw_req | swreq_w) & ~masked_w;
  assign grant_evt = (st == ST_IDLE) && !cmd_disable && any;
  assign unit_w    = (st == ST_UNIT) ? (NCH'(1) << gnt) : '0;

  dma_prio_pick #(.NCH(NCH)) u_pick (
    .elig    (elig),
    .rotate  (cmd_rotate),
    .last_srv(last_srv),
    .any     (any),
    .pick    (pick)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    dma_chan_ctx #(.OW(OW)) u_ctx (
      .clk      (clk),
      .rst_n    (rst_n),
      .base_addr(base_addr[g*OW +: OW]),
      .base_cnt (base_cnt[g*OW +: OW]),
      .dn       (ch_dec[g]),
      .auto_rl  (ch_auto[g]),
      .ld       (ld_cur[g]),
      .msk_set  (mask_set[g]),
      .msk_clr  (mask_clr[g]),
      .sw_set   (sw_req_set[g]),
      .unit     (unit_w[g]),
      .cur_addr (ca[g]),
      .cur_cnt  (cc[g]),
      .masked   (masked_w[g]),
      .sw_req   (swreq_w[g]),
      .done     (done_w[g]),
      .last_unit(last_w[g])
    );
    assign cur_addr[g*OW +: OW] = ca[g];
    assign cur_cnt[g*OW +: OW]  = cc[g];
  end

  assign gnt_mode = ch_mode[2*gnt +: 2];
  assign gnt_type = ch_type[2*gnt +: 2];
  assign gnt_req  = hw_req[gnt] | swreq_w[gnt];

  always_comb begin
    stop_evt = last_w[gnt] || masked_w[gnt];
    case (gnt_mode)
      MD_BLOCK:  ;
      MD_DEMAND: if (!gnt_req) stop_evt = 1'b1;
      default:   stop_evt = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      gnt      <= '0;
      last_srv <= '0;
    end else begin
      case (st)
        ST_IDLE: if (grant_evt) begin
          st  <= ST_UNIT;
          gnt <= pick;
        end
        ST_UNIT: if (stop_evt) begin
          st       <= ST_IDLE;
          last_srv <= gnt;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign mem_cyc    = (st == ST_UNIT);
  assign dack       = unit_w;
  assign mem_addr   = mem_cyc ? f_phys(ch_page[PGW*gnt +: PGW], ca[gnt], ch_word[gnt]) : '0;
  assign mem_rd     = mem_cyc && (gnt_type == TY_READ);
  assign mem_wr     = mem_cyc && (gnt_type == TY_WRITE);
  assign tc_pulse   = unit_w & last_w;
  assign req_flags  = hw_req | swreq_w;
  assign done_flags = done_w;
  assign ch_masked  = masked_w;

  AST_SINGLE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_cyc && gnt_mode[0]) |=> !mem_cyc); // R6
  AST_BLOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_cyc && gnt_mode == MD_BLOCK && !last_w[gnt] && !masked_w[gnt])
      |=> (mem_cyc && dack == $past(dack))); // R6
  AST_DISABLED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cyc && cmd_disable) |=> !mem_cyc); // R8
  AST_NO_MASKED_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_cyc) |-> (($past(masked_w) & dack) == '0)); // R10
  AST_TC_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (|tc_pulse) |=> (tc_pulse == '0)); // R12
  AST_STROBES_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || mem_wr) |-> ($countones(dack) == 1 && !(mem_rd && mem_wr))); // R11

endmodule

// File: tb/sim_dma_xfer_seq.sv
`timescale 1ns/1ps
module sim_dma_xfer_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_disable = 1'b0, cmd_rotate = 1'b0;
  logic [7:0]  ch_mode = '0, ch_type = '0;
  logic [3:0]  ch_dec = '0, ch_auto = '0, ch_word = '0;
  logic [31:0] ch_page = '0;
  logic [63:0] base_addr = '0, base_cnt = '0;
  logic [3:0]  ld_cur = '0, mask_set = '0, mask_clr = '0, sw_req_set = '0, hw_req = '0;
  logic        mem_cyc, mem_rd, mem_wr;
  logic [23:0] mem_addr;
  logic [3:0]  dack, tc_pulse, req_flags, done_flags, ch_masked;
  logic [63:0] cur_addr, cur_cnt;

  always #2.5 clk = ~clk;

  dma_xfer_seq u0 (.*);

  int n_tests = 0, n_fail = 0;
  bit fin = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // bench model
  logic [15:0] m_addr[4], m_cnt[4], m_ba[4], m_bc[4];
  logic [7:0]  m_pg[4];
  logic [1:0]  m_mode[4], m_type[4];
  bit          m_dec[4], m_auto[4], m_word[4], m_mask[4];
  int          units[4];
  logic [23:0] last_pa[4];
  int          seq_ch[0:4095];
  int          seq_n = 0;
  int          run = 0, max_run = 0;
  bit          prev_cyc = 0, prev_single = 0;

  function automatic logic [23:0] pa_of(input logic [7:0] pg, input logic [15:0] off, input bit wd);
    logic [31:0] v;
    if (wd) v = (32'(pg) * 32'd131072) + (32'(off) * 32'd2);
    else    v = (32'(pg & 8'h0F) * 32'd65536) + 32'(off);
    return v[23:0];
  endfunction

  function automatic logic [15:0] nxt(input logic [15:0] a, input bit dn);
    return dn ? a - 16'd1 : a + 16'd1;
  endfunction

  always @(negedge clk) begin
    if (rst_n && mem_cyc) begin
      int c;
      c = 0;
      for (int i = 0; i < 4; i++) if (dack[i]) c = i;
      chk($countones(dack) == 1, "R11 dack one-hot", 32'(dack), 32'(4'b1 << c));
      chk(mem_addr == pa_of(m_pg[c], m_addr[c], m_word[c]), "R5 address", 32'(mem_addr),
          32'(pa_of(m_pg[c], m_addr[c], m_word[c])));
      chk({mem_rd, mem_wr} == {m_type[c] == 2'b10, m_type[c] == 2'b01}, "R11 strobes",
          32'({mem_rd, mem_wr}), 32'({m_type[c] == 2'b10, m_type[c] == 2'b01}));
      chk(tc_pulse == ((m_cnt[c] == 16'd0) ? (4'b1 << c) : 4'b0), "R12 tc pulse",
          32'(tc_pulse), 32'((m_cnt[c] == 16'd0) ? (4'b1 << c) : 4'b0));
      chk(!(prev_cyc && prev_single), "R6 single gap", 32'(prev_cyc), 32'd0);
      last_pa[c] = mem_addr;
      if (m_cnt[c] == 16'd0) begin
        if (m_auto[c]) begin
          m_addr[c] = m_ba[c]; m_cnt[c] = m_bc[c];
        end else begin
          m_addr[c] = nxt(m_addr[c], m_dec[c]); m_cnt[c] = 16'hFFFF; m_mask[c] = 1'b1;
        end
      end else begin
        m_addr[c] = nxt(m_addr[c], m_dec[c]); m_cnt[c] = m_cnt[c] - 16'd1;
      end
      units[c]++;
      seq_ch[seq_n % 4096] = c;
      seq_n++;
      run = prev_cyc ? run + 1 : 1;
      if (run > max_run) max_run = run;
      prev_single = m_mode[c][0];
    end
    prev_cyc = rst_n && mem_cyc;
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic prog(input int ch, input logic [1:0] md, input logic [1:0] ty, input bit dn,
                      input bit au, input bit wd, input logic [7:0] pg,
                      input logic [15:0] a, input logic [15:0] c);
    ch_mode[ch*2 +: 2] = md; ch_type[ch*2 +: 2] = ty;
    ch_dec[ch] = dn; ch_auto[ch] = au; ch_word[ch] = wd;
    ch_page[ch*8 +: 8] = pg; base_addr[ch*16 +: 16] = a; base_cnt[ch*16 +: 16] = c;
    mask_set[ch] = 1'b1; ld_cur[ch] = 1'b1;
    tick(1);
    mask_set[ch] = 1'b0; ld_cur[ch] = 1'b0;
    m_mode[ch] = md; m_type[ch] = ty; m_dec[ch] = dn; m_auto[ch] = au; m_word[ch] = wd;
    m_pg[ch] = pg; m_ba[ch] = a; m_bc[ch] = c; m_addr[ch] = a; m_cnt[ch] = c; m_mask[ch] = 1'b1;
  endtask

  task automatic unmask(input logic [3:0] v);
    mask_clr = v; tick(1); mask_clr = '0;
    for (int i = 0; i < 4; i++) if (v[i]) m_mask[i] = 1'b0;
  endtask

  task automatic mask_all();
    mask_set = 4'hF; tick(1); mask_set = '0;
    for (int i = 0; i < 4; i++) m_mask[i] = 1'b1;
  endtask

  initial begin
    int u, s;
    bit ok;
    void'($urandom(32'd7315));
    for (int i = 0; i < 4; i++) begin units[i] = 0; m_mask[i] = 1'b1; end
    tick(3);
    rst_n = 1'b1;
    tick(1);
    // reset state
    chk(mem_cyc == 1'b0, "R10 reset idle", 32'(mem_cyc), 0);
    chk(dack == 4'b0, "R11 reset dack", 32'(dack), 0);
    chk(ch_masked == 4'hF, "R10 reset masks", 32'(ch_masked), 32'hF);
    chk(done_flags == 4'b0, "R12 reset done", 32'(done_flags), 0);

    // R1 R9: block, software start, count 2 -> 3 units
    prog(0, 2'b10, 2'b10, 0, 0, 0, 8'h05, 16'h1234, 16'd2);
    unmask(4'b0001);
    u = units[0]; max_run = 0;
    sw_req_set[0] = 1'b1; tick(1); sw_req_set[0] = 1'b0;
    tick(10);
    chk(units[0] - u == 3, "R1 unit count", 32'(units[0] - u), 3);
    chk(max_run == 3, "R6 block back-to-back", 32'(max_run), 3);
    chk(cur_cnt[15:0] == 16'hFFFF, "R1 count after tc", 32'(cur_cnt[15:0]), 32'hFFFF);
    chk(cur_addr[15:0] == 16'h1237, "R2 offset up", 32'(cur_addr[15:0]), 32'h1237);
    chk(ch_masked[0] == 1'b1, "R4 self mask", 32'(ch_masked[0]), 1);
    chk(done_flags[0] == 1'b1, "R12 done set", 32'(done_flags[0]), 1);
    chk(req_flags[0] == 1'b0, "R9 sw request cleared", 32'(req_flags[0]), 0);

    // R3: word channel, down, wraps through zero
    prog(1, 2'b10, 2'b01, 1, 0, 1, 8'h12, 16'h0001, 16'd3);
    unmask(4'b0010);
    u = units[1];
    sw_req_set[1] = 1'b1; tick(1); sw_req_set[1] = 1'b0;
    tick(10);
    chk(units[1] - u == 4, "R1 word unit count", 32'(units[1] - u), 4);
    chk(cur_addr[31:16] == 16'hFFFD, "R3 offset wrap", 32'(cur_addr[31:16]), 32'hFFFD);
    chk(last_pa[1] == 24'h25FFFC, "R3 page fixed", 32'(last_pa[1]), 32'h25FFFC);

    // R4: auto-reload, single mode, verify type
    prog(2, 2'b01, 2'b00, 0, 1, 0, 8'h03, 16'h0010, 16'd1);
    unmask(4'b0100);
    u = units[2];
    hw_req[2] = 1'b1; tick(3); hw_req[2] = 1'b0;
    tick(6);
    chk(units[2] - u == 2, "R6 single units", 32'(units[2] - u), 2);
    chk(cur_addr[47:32] == 16'h0010, "R4 offset reload", 32'(cur_addr[47:32]), 32'h10);
    chk(cur_cnt[47:32] == 16'd1, "R4 count reload", 32'(cur_cnt[47:32]), 1);
    chk(ch_masked[2] == 1'b0, "R4 stays armed", 32'(ch_masked[2]), 0);
    chk(done_flags[2] == 1'b1, "R12 done on auto", 32'(done_flags[2]), 1);
    ld_cur[2] = 1'b1; tick(1); ld_cur[2] = 1'b0;
    chk(done_flags[2] == 1'b0, "R12 done cleared by load", 32'(done_flags[2]), 0);

    // R6: demand mode follows the request
    prog(3, 2'b00, 2'b10, 0, 0, 0, 8'h01, 16'h0000, 16'd100);
    unmask(4'b1000);
    u = units[3]; max_run = 0;
    hw_req[3] = 1'b1; tick(6); hw_req[3] = 1'b0;
    tick(10);
    chk(units[3] - u == 6, "R6 demand units", 32'(units[3] - u), 6);
    chk(max_run == 6, "R6 demand back-to-back", 32'(max_run), 6);
    chk(cur_cnt[63:48] == 16'd94, "R2 demand count", 32'(cur_cnt[63:48]), 94);

    // R10: masked channel ignores its request
    mask_set[3] = 1'b1; tick(1); mask_set[3] = 1'b0; m_mask[3] = 1'b1;
    u = units[3];
    hw_req[3] = 1'b1; tick(10);
    chk(units[3] == u, "R10 masked no units", 32'(units[3] - u), 0);
    chk(cur_cnt[63:48] == 16'd94, "R10 masked count unchanged", 32'(cur_cnt[63:48]), 94);
    hw_req[3] = 1'b0;

    // R8: controller disable
    unmask(4'b1000);
    cmd_disable = 1'b1; hw_req[3] = 1'b1; tick(10);
    chk(units[3] == u, "R8 disabled no units", 32'(units[3] - u), 0);
    cmd_disable = 1'b0; tick(3);
    chk(units[3] > u, "R8 resumes", 32'(units[3] - u), 1);
    hw_req[3] = 1'b0; tick(4);
    mask_all();

    // R7: fixed then rotating priority
    for (int i = 0; i < 4; i++) prog(i, 2'b01, 2'b00, 0, 0, 0, 8'h00, 16'h0100, 16'd50);
    unmask(4'hF);
    cmd_rotate = 1'b0;
    s = seq_n;
    hw_req = 4'hF; tick(8); hw_req = 4'h0; tick(4);
    ok = (seq_n - s) >= 2;
    for (int k = s; k < seq_n; k++) if (seq_ch[k % 4096] != 0) ok = 0;
    chk(ok, "R7 fixed priority", 32'(seq_n - s), 4);
    cmd_rotate = 1'b1;
    s = seq_n;
    hw_req = 4'hF; tick(16); hw_req = 4'h0; tick(4);
    ok = (seq_n - s) >= 4 && seq_ch[s % 4096] == 1;
    for (int k = s + 1; k < seq_n; k++)
      if (seq_ch[k % 4096] != ((seq_ch[(k - 1) % 4096] + 1) % 4)) ok = 0;
    chk(ok, "R7 rotating priority", 32'(seq_ch[s % 4096]), 1);
    mask_all();

    // constrained random rounds
    for (int r = 0; r < 8; r++) begin
      for (int i = 0; i < 4; i++) begin
        logic [1:0] md;
        bit dn;
        logic [15:0] a;
        md = 2'($urandom % 3);
        dn = 1'($urandom);
        a  = (($urandom % 4) == 0) ? (dn ? 16'h0002 : 16'hFFFD) : 16'($urandom);
        prog(i, md, 2'($urandom), dn, 1'($urandom), 1'($urandom), 8'($urandom), a,
             16'($urandom % 8));
      end
      cmd_rotate = 1'($urandom);
      unmask(4'hF);
      for (int t = 0; t < 120; t++) begin
        hw_req = 4'($urandom);
        tick(1);
      end
      hw_req = 4'h0;
      tick(50);
      for (int i = 0; i < 4; i++)
        chk(ch_masked[i] == m_mask[i], "R4 mask after random run", 32'(ch_masked[i]), 32'(m_mask[i]));
      mask_all();
    end

    fin = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!fin) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule